// File: doc/BRIEF.md
# Four-Channel PWM High-Side Output Controller

This block produces the gate-enable levels for four high-side power switches. Each channel has an enable bit, a 7-bit duty code, a 3-bit phase-delay code and a direct-pin enable. A global PWM enable and a clock-source select apply to all four channels. A free-running 7-bit period counter advances once per PWM tick, so one output period spans 128 ticks. The tick is either the rising edge of channel 0's input pin, brought into the system clock domain first, or a strobe from an internal calibrated tick source. The calibrated source is outside this block.

A monitor counts the edges on the external pin over a fixed window of system clocks. When the count falls outside a programmable minimum/maximum band, a clock-fail flag is raised. While that flag is set, the external source is selected and PWM is enabled, each channel drops to plain enable-bit control. When the wake input and all four channel pins are low, the block sleeps: it treats every configuration field as zero and holds every output off. Configuration arrives as already-decoded fields. Duty and delay codes are captured only at a period boundary while the channel is modulating.

Top module: `hs_pwm_ctrl`

## Requirements
- R1: While `wake_i` and all bits of `dir_in_i` are low, `sleep_o` is 1, and `hs_o` is 0 from the next clock onward.
- R2: With `pwm_en_i`=0 and the block awake, channel k follows its input pin `dir_in_i[k]` when `dir_en_i[k]`=1, and follows `on_i[k]` otherwise.
- R3: With `pwm_en_i`=1 and `on_i[k]`=0, output k is 0 whatever its duty and delay codes are.
- R4: With `pwm_en_i`=1 and `on_i[k]`=1, duty code n (field `duty_i[7k+6:7k]`) keeps output k high for n+1 of every 128 PWM ticks.
- R5: Duty code 127 holds the output high for the whole period.
- R6: Delay code d (field `delay_i[3k+2:3k]`) moves the rising edge of channel k by 16·d PWM ticks, relative to a channel with code 0.
- R7: With `clk_sel_i`=1 the PWM tick is the `int_tick_i` strobe. With `clk_sel_i`=0 the tick is each rising edge of `dir_in_i[0]`, and `int_tick_i` is ignored.
- R8: At the end of each monitor window, `clk_fail_o` becomes 1 if the number of rising edges of `dir_in_i[0]` in that window is below `mon_min_i` or above `mon_max_i`, and becomes 0 otherwise. Its reset value is 1.
- R9: With `clk_fail_o`=1, `clk_sel_i`=0 and `pwm_en_i`=1, each output follows `on_i[k]` steadily.
- R10: A duty code written in the middle of a period does not affect the output until the next period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_i | input | 1 | Wake request; low together with all pins allows sleep |
| dir_in_i | input | NCH | Channel input pins; bit 0 also carries the external PWM clock |
| int_tick_i | input | 1 | One-cycle strobe from the internal calibrated tick source |
| pwm_en_i | input | 1 | Global PWM enable |
| clk_sel_i | input | 1 | PWM tick source: 0 external pin, 1 internal strobe |
| on_i | input | NCH | Per-channel enable bits |
| dir_en_i | input | NCH | Per-channel direct-pin control enable |
| duty_i | input | NCH*DUTY_W | Packed duty codes, channel k in bits [DUTY_W*k +: DUTY_W] |
| delay_i | input | NCH*DLY_W | Packed delay codes, channel k in bits [DLY_W*k +: DLY_W] |
| mon_min_i | input | MON_W | Lowest acceptable edge count per monitor window |
| mon_max_i | input | MON_W | Highest acceptable edge count per monitor window |
| hs_o | output | NCH | Switch enable per channel |
| clk_fail_o | output | 1 | External PWM clock out of range |
| sleep_o | output | 1 | Block is in sleep |

## Verification
The bench keeps the default channel count, duty width, delay width and delay step. It shortens the monitor window to 64 system clocks. A short window lets one test run move the fail flag both ways: through a too-fast edge rate, a stopped clock and an in-band rate, with a few hundred cycles per step. It drives the internal strobe every 4 cycles and the external pin with a 2- or 8-cycle period. This makes one output period 512 or 1024 cycles, so a duty ratio and a phase shift can be measured exactly over a single period.

// File: rtl/hsp_pkg.sv
// Package: shared types for the PWM high-side controller.
// Assumes nothing beyond IEEE 1800-2017.
package hsp_pkg;

    // How a channel output is being driven in a given cycle
    typedef enum logic [1:0] {
        DRV_OFF      = 2'd0,
        DRV_DIRECT   = 2'd1,
        DRV_PWM      = 2'd2,
        DRV_FALLBACK = 2'd3
    } drv_mode_e;

endpackage

// File: rtl/hsp_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a slow level or a clock well below the system clock, so
// per-bit skew is harmless. Reset clears every stage.
module hsp_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: sample the raw asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[0] <= '0;
                    else        stg_q[0] <= d_i;
                end
            end else begin : g_next
                // Later stages: pass the previous stage along
                always_ff @(posedge clk) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hsp_clk_mon.sv
// Module: external clock monitor. Counts edge strobes over a window of
// MON_WIN system clocks. At the end of each window it flags a failure when
// the count lies outside [min_i, max_i].
// Assumes edge_i is a one-cycle strobe per external edge. The count saturates.
// The flag resets to 1: no valid clock has been seen yet.
module hsp_clk_mon #(
    parameter int MON_WIN = 256,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] min_i,
    input  logic [CNT_W-1:0] max_i,
    output logic             fail_o
);

    localparam int WIN_W = (MON_WIN > 1) ? $clog2(MON_WIN) : 1;

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] edg_q;
    logic [CNT_W-1:0] edg_nxt;
    logic             win_end;

    assign win_end = (win_q == WIN_W'(MON_WIN - 1));
    assign edg_nxt = (edge_i && (edg_q != '1)) ? edg_q + 1'b1 : edg_q;

    // Window timer: counts system clocks and restarts at each window end
    always_ff @(posedge clk) begin
        if (!rst_n)       win_q <= '0;
        else if (win_end) win_q <= '0;
        else              win_q <= win_q + 1'b1;
    end

    // Edge counter: accumulates strobes and clears at each window end
    always_ff @(posedge clk) begin
        if (!rst_n)       edg_q <= '0;
        else if (win_end) edg_q <= '0;
        else              edg_q <= edg_nxt;
    end

    // Verdict: compare the final window count against the allowed band
    always_ff @(posedge clk) begin
        if (!rst_n)       fail_o <= 1'b1;
        else if (win_end) fail_o <= (edg_nxt < min_i) || (edg_nxt > max_i);
    end

endmodule

// File: rtl/hsp_period_cnt.sv
// Module: free-running PWM period counter. Advances once per tick and wraps
// after 2**CW ticks. wrap_o marks the tick that starts a new period.
// Assumes tick_i is a one-cycle strobe. clear_i holds the counter at zero.
module hsp_period_cnt #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          tick_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o
);

    logic [CW-1:0] cnt_q;

    // Period position: step on each tick, hold at zero while cleared
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (tick_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && !clear_i && (cnt_q == '1);

endmodule

// File: rtl/hsp_chan.sv
// Module: one output channel. Chooses among off, direct, PWM and fallback
// drive and registers the switch enable. Duty and delay codes are captured
// at a period boundary while modulating, and continuously otherwise.
// Assumes cnt_i and wrap_i come from the shared period counter and that the
// configuration inputs have already been forced to zero during sleep.
module hsp_chan
    import hsp_pkg::*;
#(
    parameter int CW        = 7,
    parameter int DLY_W     = 3,
    parameter int DLY_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             awake_i,
    input  logic             pwm_en_i,
    input  logic             fallback_i,
    input  logic             on_i,
    input  logic             dir_en_i,
    input  logic             pin_i,
    input  logic             wrap_i,
    input  logic [CW-1:0]    cnt_i,
    input  logic [CW-1:0]    duty_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             hs_o
);

    logic [CW-1:0]    duty_q;
    logic [DLY_W-1:0] dly_q;
    logic [CW-1:0]    offs;
    logic [CW-1:0]    phase;
    logic             pwm_act;
    logic             pwm_bit;
    logic             hs_nxt;
    drv_mode_e        mode;

    assign pwm_act = awake_i && pwm_en_i && on_i && !fallback_i;

    // Code capture: only at a period boundary while modulating, so no runt pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            dly_q  <= '0;
        end else if (!pwm_act || wrap_i) begin
            duty_q <= duty_i;
            dly_q  <= dly_i;
        end
    end

    assign offs    = CW'({dly_q, {DLY_SHIFT{1'b0}}});
    assign phase   = cnt_i - offs;
    assign pwm_bit = (phase <= duty_q);

    // Drive mode selection: sleep, then clock fallback, then PWM, then direct
    always_comb begin
        if (!awake_i)        mode = DRV_OFF;
        else if (fallback_i) mode = DRV_FALLBACK;
        else if (pwm_en_i)   mode = DRV_PWM;
        else                 mode = DRV_DIRECT;
    end

    // Next output level for the chosen mode
    always_comb begin
        unique case (mode)
            DRV_OFF:      hs_nxt = 1'b0;
            DRV_FALLBACK: hs_nxt = on_i;
            DRV_PWM:      hs_nxt = on_i && pwm_bit;
            DRV_DIRECT:   hs_nxt = dir_en_i ? pin_i : on_i;
            default:      hs_nxt = 1'b0;
        endcase
    end

    // Output register: glitch-free switch enable
    always_ff @(posedge clk) begin
        if (!rst_n) hs_o <= 1'b0;
        else        hs_o <= hs_nxt;
    end

endmodule

// File: rtl/hs_pwm_ctrl.sv
// Module: four-channel PWM high-side output controller (top).
// Synchronizes the wake input and the channel pins and detects sleep. Gates
// the configuration, selects the PWM tick source, monitors the external clock,
// and runs one period counter shared by NCH channel instances.
// Assumes the configuration fields are static or change synchronously to clk,
// and that int_tick_i is a clean one-cycle strobe in the clk domain.
module hs_pwm_ctrl
    import hsp_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DUTY_W      = 7,
    parameter int DLY_W       = 3,
    parameter int DLY_SHIFT   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MON_WIN     = 256,
    parameter int MON_W       = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wake_i,
    input  logic [NCH-1:0]          dir_in_i,
    input  logic                    int_tick_i,
    input  logic                    pwm_en_i,
    input  logic                    clk_sel_i,
    input  logic [NCH-1:0]          on_i,
    input  logic [NCH-1:0]          dir_en_i,
    input  logic [NCH*DUTY_W-1:0]   duty_i,
    input  logic [NCH*DLY_W-1:0]    delay_i,
    input  logic [MON_W-1:0]        mon_min_i,
    input  logic [MON_W-1:0]        mon_max_i,
    output logic [NCH-1:0]          hs_o,
    output logic                    clk_fail_o,
    output logic                    sleep_o
);

    localparam int SYN_W = NCH + 1;

    logic [SYN_W-1:0]        syn_q;
    logic [NCH-1:0]          pin_s;
    logic                    wake_s;
    logic                    pin0_d;
    logic                    ext_rise;
    logic                    awake;
    logic                    tick;
    logic                    mon_fail;
    logic                    fallback;
    logic [DUTY_W-1:0]       cnt;
    logic                    wrap;
    logic                    cfg_pwm_en;
    logic                    cfg_sel;
    logic [NCH-1:0]          cfg_on;
    logic [NCH-1:0]          cfg_dir_en;
    logic [NCH*DUTY_W-1:0]   cfg_duty;
    logic [NCH*DLY_W-1:0]    cfg_dly;

    hsp_sync #(
        .W      (SYN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wake_i, dir_in_i}),
        .q_o   (syn_q)
    );

    assign pin_s  = syn_q[NCH-1:0];
    assign wake_s = syn_q[NCH];

    // Edge history of the external clock pin
    always_ff @(posedge clk) begin
        if (!rst_n) pin0_d <= 1'b0;
        else        pin0_d <= pin_s[0];
    end

    assign ext_rise = pin_s[0] && !pin0_d;
    assign awake    = wake_s || (|pin_s);
    assign sleep_o  = !awake;

    // Sleep gating: every configuration field reads as zero while asleep
    always_comb begin
        cfg_pwm_en = awake ? pwm_en_i  : 1'b0;
        cfg_sel    = awake ? clk_sel_i : 1'b0;
        cfg_on     = awake ? on_i      : '0;
        cfg_dir_en = awake ? dir_en_i  : '0;
        cfg_duty   = awake ? duty_i    : '0;
        cfg_dly    = awake ? delay_i   : '0;
    end

    assign tick = cfg_sel ? int_tick_i : ext_rise;

    hsp_clk_mon #(
        .MON_WIN (MON_WIN),
        .CNT_W   (MON_W)
    ) u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .edge_i (ext_rise),
        .min_i  (mon_min_i),
        .max_i  (mon_max_i),
        .fail_o (mon_fail)
    );

    assign clk_fail_o = mon_fail;
    assign fallback   = cfg_pwm_en && !cfg_sel && mon_fail;

    hsp_period_cnt #(
        .CW (DUTY_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!awake),
        .tick_i  (tick),
        .cnt_o   (cnt),
        .wrap_o  (wrap)
    );

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_ch
            hsp_chan #(
                .CW        (DUTY_W),
                .DLY_W     (DLY_W),
                .DLY_SHIFT (DLY_SHIFT)
            ) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .awake_i    (awake),
                .pwm_en_i   (cfg_pwm_en),
                .fallback_i (fallback),
                .on_i       (cfg_on[k]),
                .dir_en_i   (cfg_dir_en[k]),
                .pin_i      (pin_s[k]),
                .wrap_i     (wrap),
                .cnt_i      (cnt),
                .duty_i     (cfg_duty[k*DUTY_W +: DUTY_W]),
                .dly_i      (cfg_dly[k*DLY_W +: DLY_W]),
                .hs_o       (hs_o[k])
            );
        end
    endgenerate

endmodule

// File: rtl/hsp_checker.sv
// Module: protocol checker for hs_pwm_ctrl, attached through bind.
// Observes ports only. Each property is tied to a requirement by its label.
module hsp_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwm_en_i,
    input logic           clk_sel_i,
    input logic [NCH-1:0] on_i,
    input logic [NCH-1:0] dir_en_i,
    input logic [NCH-1:0] hs_o,
    input logic           clk_fail_o,
    input logic           sleep_o
);

    // Sleep forces every output off on the following cycle
    assert_sleep_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> (hs_o == '0));

    // Clock fallback: outputs track the enable bits steadily
    assert_fallback_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && pwm_en_i && !clk_sel_i && clk_fail_o) |=> (hs_o == $past(on_i)));

    generate
        for (genvar k = 0; k < NCH; k++) begin : g_chk
            // Disabled channel under PWM stays off
            assert_off_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (pwm_en_i && !on_i[k]) |=> !hs_o[k]);

            // Without PWM or direct control the output copies the enable bit
            assert_on_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (!sleep_o && !pwm_en_i && !dir_en_i[k]) |=> (hs_o[k] == $past(on_i[k])));
        end
    endgenerate

endmodule

bind hs_pwm_ctrl hsp_checker #(.NCH(NCH)) u_hsp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_en_i   (pwm_en_i),
    .clk_sel_i  (clk_sel_i),
    .on_i       (on_i),
    .dir_en_i   (dir_en_i),
    .hs_o       (hs_o),
    .clk_fail_o (clk_fail_o),
    .sleep_o    (sleep_o)
);

// File: tb/test_hs_pwm_ctrl.sv
// Directed bench for hs_pwm_ctrl: one task per scenario, each checking itself.
// 250 MHz clock (4-unit period). Inputs are driven and outputs sampled on the
// falling edge.
module test_hs_pwm_ctrl;

    localparam int NCH   = 4;
    localparam int DW    = 7;
    localparam int LW    = 3;
    localparam int MW    = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wake_i;
    logic [NCH-1:0]    dir_in_i;
    logic              int_tick_i;
    logic              pwm_en_i;
    logic              clk_sel_i;
    logic [NCH-1:0]    on_i;
    logic [NCH-1:0]    dir_en_i;
    logic [NCH*DW-1:0] duty_i;
    logic [NCH*LW-1:0] delay_i;
    logic [MW-1:0]     mon_min_i;
    logic [MW-1:0]     mon_max_i;
    logic [NCH-1:0]    hs_o;
    logic              clk_fail_o;
    logic              sleep_o;

    logic [NCH-1:0]    pins_man;
    logic              ext_run;
    int                ext_half;
    int                ediv;
    logic              ext_tog;
    int                tdiv;

    int                n_checks;
    int                n_errors;
    int                hi_cnt [NCH];

    always #2 clk = ~clk;

    hs_pwm_ctrl #(.MON_WIN(64)) i_hs_pwm_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_i     (wake_i),
        .dir_in_i   (dir_in_i),
        .int_tick_i (int_tick_i),
        .pwm_en_i   (pwm_en_i),
        .clk_sel_i  (clk_sel_i),
        .on_i       (on_i),
        .dir_en_i   (dir_en_i),
        .duty_i     (duty_i),
        .delay_i    (delay_i),
        .mon_min_i  (mon_min_i),
        .mon_max_i  (mon_max_i),
        .hs_o       (hs_o),
        .clk_fail_o (clk_fail_o),
        .sleep_o    (sleep_o)
    );

    assign dir_in_i = ext_run ? {pins_man[NCH-1:1], ext_tog} : pins_man;

    // Internal tick strobe every 4 system clocks
    always @(negedge clk) begin
        tdiv       <= (tdiv == 3) ? 0 : tdiv + 1;
        int_tick_i <= (tdiv == 3);
    end

    // External clock on pin 0: toggles every ext_half system clocks
    always @(negedge clk) begin
        if (ext_run) begin
            if (ediv >= ext_half - 1) begin
                ediv    <= 0;
                ext_tog <= ~ext_tog;
            end else begin
                ediv <= ediv + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count high cycles per channel over n cycles
    task automatic measure(input int n);
        for (int k = 0; k < NCH; k++) hi_cnt[k] = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int k = 0; k < NCH; k++) if (hs_o[k]) hi_cnt[k]++;
        end
    endtask

    task automatic set_duty(input int k, input int v);
        duty_i[k*DW +: DW] = DW'(v);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cycles(5);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset fail flag", clk_fail_o, 1);
        check("R1 reset outputs", hs_o, 0);
        check("R1 reset sleep", sleep_o, 1);
    endtask

    task automatic t_sleep();
        wake_i = 1'b0; pins_man = '0; on_i = '1; pwm_en_i = 1'b0; dir_en_i = '0;
        cycles(8);
        check("R1 sleep outputs off", hs_o, 0);
        check("R1 sleep flag", sleep_o, 1);
        wake_i = 1'b1;
        cycles(8);
        check("R1 woken by wake", sleep_o, 0);
        check("R2 on-follow after wake", hs_o, 4'hF);
        wake_i = 1'b0; pins_man = 4'b0100;
        cycles(8);
        check("R1 kept awake by pin", sleep_o, 0);
        check("R2 on-follow pin awake", hs_o, 4'hF);
    endtask

    task automatic t_direct();
        wake_i = 1'b1; pwm_en_i = 1'b0; dir_en_i = 4'b0101; on_i = 4'b1000;
        pins_man = 4'b0100;
        cycles(8);
        check("R2 direct pattern A", hs_o, 4'b1100);
        pins_man = 4'b0001;
        cycles(8);
        check("R2 direct pattern B", hs_o, 4'b1001);
        dir_en_i = '0; pins_man = '0;
    endtask

    task automatic t_off();
        clk_sel_i = 1'b1; pwm_en_i = 1'b1; on_i = '0;
        for (int k = 0; k < NCH; k++) set_duty(k, 127);
        measure(600);
        for (int k = 0; k < NCH; k++) check("R3 disabled channel off", hi_cnt[k], 0);
    endtask

    task automatic t_duty(input int d0, input int d1, input int d2, input int d3);
        clk_sel_i = 1'b1; pwm_en_i = 1'b1; on_i = '1; delay_i = '0;
        set_duty(0, d0); set_duty(1, d1); set_duty(2, d2); set_duty(3, d3);
        cycles(1100);
        measure(512);
        check("R4 R7 duty ch0", hi_cnt[0], (d0 + 1) * 4);
        check("R4 R7 duty ch1", hi_cnt[1], (d1 + 1) * 4);
        check("R4 R7 duty ch2", hi_cnt[2], (d2 + 1) * 4);
        check((d3 == 127) ? "R5 full on ch3" : "R4 duty ch3", hi_cnt[3], (d3 + 1) * 4);
    endtask

    task automatic t_delay();
        logic [NCH-1:0] samp [1200];
        int i0;
        int dcode [NCH];
        dcode[0] = 0; dcode[1] = 3; dcode[2] = 7; dcode[3] = 1;
        clk_sel_i = 1'b1; pwm_en_i = 1'b1; on_i = '1;
        for (int k = 0; k < NCH; k++) begin
            set_duty(k, 31);
            delay_i[k*LW +: LW] = LW'(dcode[k]);
        end
        cycles(1100);
        for (int i = 0; i < 1200; i++) begin
            @(negedge clk);
            samp[i] = hs_o;
        end
        i0 = -1;
        for (int i = 1; i < 600; i++)
            if (i0 < 0 && samp[i][0] && !samp[i-1][0]) i0 = i;
        check("R6 reference edge found", (i0 > 0) ? 1 : 0, 1);
        for (int k = 1; k < NCH; k++) begin
            int jk = -1;
            for (int j = ((i0 > 0) ? i0 : 1); j < 1200; j++)
                if (jk < 0 && samp[j][k] && !samp[j-1][k]) jk = j;
            check("R6 edge shift", jk - i0, 64 * dcode[k]);
        end
        delay_i = '0;
    endtask

    task automatic t_boundary();
        int guard;
        logic prev;
        clk_sel_i = 1'b1; pwm_en_i = 1'b1; on_i = 4'b0001; delay_i = '0;
        set_duty(0, 10);
        cycles(1100);
        guard = 0;
        prev  = hs_o[0];
        @(negedge clk);
        while (!(prev && !hs_o[0]) && guard < 1000) begin
            prev = hs_o[0];
            @(negedge clk);
            guard++;
        end
        set_duty(0, 100);
        measure(440);
        check("R10 mid-period code ignored", hi_cnt[0], 0);
        cycles(1100);
        measure(512);
        check("R10 code applied next period", hi_cnt[0], 101 * 4);
    endtask

    task automatic t_ext();
        clk_sel_i = 1'b0; ext_half = 4; ext_run = 1'b1;
        pwm_en_i = 1'b0; on_i = 4'b0001; delay_i = '0;
        mon_min_i = 8'd4; mon_max_i = 8'd12;
        set_duty(0, 31);
        cycles(300);
        check("R8 in-band clock ok", clk_fail_o, 0);
        pwm_en_i = 1'b1;
        cycles(2100);
        measure(1024);
        check("R7 external tick duty", hi_cnt[0], 32 * 8);
    endtask

    task automatic t_fail();
        on_i = 4'b0101; set_duty(0, 31); set_duty(2, 0);
        ext_half = 1;
        cycles(200);
        check("R8 too fast flagged", clk_fail_o, 1);
        measure(200);
        check("R9 fallback ch0 on", hi_cnt[0], 200);
        check("R9 fallback ch1 off", hi_cnt[1], 0);
        check("R9 fallback ch2 on", hi_cnt[2], 200);
        ext_run = 1'b0; pins_man = '0;
        cycles(200);
        check("R8 stopped clock flagged", clk_fail_o, 1);
        ext_half = 4; ext_run = 1'b1;
        cycles(200);
        check("R8 recovery", clk_fail_o, 0);
        cycles(2100);
        measure(1024);
        check("R9 PWM resumes ch0", hi_cnt[0], 32 * 8);
        check("R9 PWM resumes ch2", hi_cnt[2], 1 * 8);
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        cycles(100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        n_checks = 0; n_errors = 0;
        tdiv = 0; int_tick_i = 1'b0;
        ediv = 0; ext_tog = 1'b0; ext_run = 1'b0; ext_half = 4;
        rst_n = 1'b0; wake_i = 1'b0; pins_man = '0;
        pwm_en_i = 1'b0; clk_sel_i = 1'b1; on_i = '0; dir_en_i = '0;
        duty_i = '0; delay_i = '0; mon_min_i = 8'd4; mon_max_i = 8'd12;
        t_reset();
        t_sleep();
        t_direct();
        t_off();
        t_duty(0, 1, 63, 126);
        t_duty(5, 40, 100, 127);
        t_delay();
        t_boundary();
        t_ext();
        t_fail();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule